// File: doc/BRIEF.md
# Width-Aware Card Byte Data Path

This block sits between a host register port and the byte stream of a memory card. It holds one 32-byte queue for each direction. A host access moves 1, 2 or 4 bytes at a time. The first byte of every access occupies the most significant lane of the access word. The card side moves one byte per clock.

A command sequencer starts a transfer with a one-cycle load pulse. The pulse carries a byte count and a direction. The count then sets how long the transfer runs and which completion events appear. The host refills the outgoing queue when the transmit request is high, and drains the incoming queue when the receive request is high. A flush pulse discards a partly filled outgoing queue, so that a short burst can be rewritten.

The controller is a four-state machine:
- **XF_IDLE**: nothing moves.
- **XF_TOCARD**: bytes leave the transmit queue toward the card.
- **XF_FROMCARD**: bytes enter the receive queue from the card.
- **XF_DONE**: a one-cycle completion state.

Its transitions are:
- **load**: from any state to XF_TOCARD or XF_FROMCARD, depending on direction. A zero count goes straight to XF_DONE.
- **last byte**: XF_TOCARD or XF_FROMCARD to XF_DONE, when the final byte moves.
- **retire**: XF_DONE to XF_IDLE.

Top module: `sd_byte_datapath`

## Requirements
- R1: After reset, `active`, `tx_req`, `rx_req`, `data_done`, `prog_done`, `card_tx_en` and `card_rx_en` are all low, and `host_rdata` is zero.
- R2: `host_size` selects the access width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. A host write of N bytes enqueues `host_wdata` lane N-1 first and lane 0 last, where lane L is bits 8L+7..8L. The card receives the bytes in that order.
- R3: The transmit queue holds at most 32 bytes. Bytes of a host write that find it full are dropped.
- R4: In the card-bound direction, one byte leaves per cycle when three conditions hold: `card_tx_ready` is high, the queue is non-empty, and bytes remain. `tx_req` is high in every cycle of an active card-bound transfer.
- R5: In the host-bound direction, one byte per cycle is pulled (`card_rx_en`) while bytes remain and the receive queue holds fewer than 32. Each pull sets `rx_req`. A host read clears `rx_req`, unless a pull happens in the same cycle.
- R6: A host read of N bytes returns the oldest byte in lane N-1 and later bytes in lower lanes. Lanes with no data, and lanes at or above N, read as zero. `host_rdata` changes on the clock edge that samples `host_rd`.
- R7: When the remaining count reaches zero, `active` falls and `data_done` pulses for exactly one cycle. `prog_done` pulses with it only for a card-bound transfer.
- R8: While not active, no byte moves on either card port, `tx_req` stays low, and no host write reaches the card.
- R9: A `tx_flush` pulse empties the transmit queue. Bytes written before the flush never reach the card.
- R10: A load empties both queues and clears `rx_req`. A load with a zero count completes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_load | input | 1 | One-cycle pulse that starts a transfer |
| xfer_count | input | CNT_W | Number of bytes to transfer |
| xfer_to_card | input | 1 | 1 = card-bound (write), 0 = host-bound (read) |
| host_size | input | 2 | Access width code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| host_wr | input | 1 | Host write to the transmit port |
| host_wdata | input | 8*BUS_BYTES | Host write data |
| host_rd | input | 1 | Host read of the receive port |
| host_rdata | output | 8*BUS_BYTES | Host read data, registered |
| tx_flush | input | 1 | Discard the transmit queue contents |
| card_tx_ready | input | 1 | Card can accept a byte this cycle |
| card_tx_en | output | 1 | A byte is handed to the card this cycle |
| card_tx_data | output | 8 | Byte handed to the card |
| card_rx_en | output | 1 | A byte is taken from the card this cycle |
| card_rx_data | input | 8 | Byte offered by the card |
| active | output | 1 | A transfer is in progress |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| data_done | output | 1 | One-cycle transfer-complete pulse |
| prog_done | output | 1 | One-cycle write-complete pulse |

## Verification
The card-bound path is tried in three ways, and each exposes a different fault:
- A mix of 4-, 2- and 1-byte writes against a 6-byte count tests lane ordering, and shows that a surplus byte stays in the queue.
- A 36-byte fill against a stalled card separates the capacity limit from the drain logic.
- A flush in the middle of a transfer shows whether discarded bytes leak out.

The host-bound path is tried in two ways:
- A short transfer read back at widths 4, 2 and 1 checks lane packing and the zero fill of empty lanes.
- A 40-byte transfer left unread checks that pulling stops at 32 bytes and resumes after each read.

Zero-count loads, loads that clear leftover receive data, and host writes while idle cover the completion and inactivity rules.

// File: rtl/sdbp_pkg.sv
package sdbp_pkg;

    typedef enum logic [1:0] {
        XF_IDLE     = 2'd0,
        XF_TOCARD   = 2'd1,
        XF_FROMCARD = 2'd2,
        XF_DONE     = 2'd3
    } xfer_state_t;

    // Access width code to byte count: 0 -> 1, 1 -> 2, otherwise 4.
    function automatic int unsigned size_to_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/sdbp_lane_fifo.sv
// Byte queue with up to LANES pushes and LANES pops per cycle.
// DEPTH must be a power of two: the pointers wrap by natural overflow.
module sdbp_lane_fifo #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic [NW-1:0]         push_n,
    input  logic [LANES-1:0][7:0] push_bytes,
    input  logic [NW-1:0]         pop_n,
    output logic [LANES-1:0][7:0] peek,
    output logic [CW-1:0]         level
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Storage: push_bytes[0] is the oldest byte of the access.
    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (!clear && (k < int'(push_n))) begin
                mem[PW'(wr_ptr + PW'(k))] <= push_bytes[k];
            end
        end
    end

    // Pointers and fill level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_n);
            rd_ptr <= rd_ptr + PW'(pop_n);
            level  <= level + CW'(push_n) - CW'(pop_n);
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_peek
            assign peek[g] = mem[PW'(rd_ptr + PW'(g))];
        end
    endgenerate

endmodule

// File: rtl/sdbp_xfer_fsm.sv
module sdbp_xfer_fsm
    import sdbp_pkg::*;
#(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic             load_to_card,
    input  logic             tx_nonempty,
    input  logic             rx_full,
    input  logic             card_tx_ready,
    input  logic             host_rd,
    output logic             active,
    output logic             card_tx_en,
    output logic             card_rx_en,
    output logic             tx_req,
    output logic             rx_req,
    output logic             data_done,
    output logic             prog_done
);

    xfer_state_t      state_q;
    xfer_state_t      state_d;
    logic [CNT_W-1:0] remain_q;
    logic             to_card_q;
    logic             rx_req_q;
    logic             last_byte;

    assign last_byte = (remain_q == CNT_W'(1));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE:     state_d = XF_IDLE;
            XF_TOCARD:   if (card_tx_en && last_byte) state_d = XF_DONE;
            XF_FROMCARD: if (card_rx_en && last_byte) state_d = XF_DONE;
            XF_DONE:     state_d = XF_IDLE;
            default:     state_d = XF_IDLE;
        endcase
        if (load) begin
            if (load_count == '0)  state_d = XF_DONE;
            else if (load_to_card) state_d = XF_TOCARD;
            else                   state_d = XF_FROMCARD;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    // Remaining count, direction and receive request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q  <= '0;
            to_card_q <= 1'b0;
            rx_req_q  <= 1'b0;
        end else if (load) begin
            remain_q  <= load_count;
            to_card_q <= load_to_card;
            rx_req_q  <= 1'b0;
        end else begin
            if (card_tx_en || card_rx_en) remain_q <= remain_q - CNT_W'(1);
            if (card_rx_en)   rx_req_q <= 1'b1;
            else if (host_rd) rx_req_q <= 1'b0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        active     = 1'b0;
        card_tx_en = 1'b0;
        card_rx_en = 1'b0;
        tx_req     = 1'b0;
        data_done  = 1'b0;
        prog_done  = 1'b0;
        unique case (state_q)
            XF_IDLE: ;
            XF_TOCARD: begin
                active     = 1'b1;
                tx_req     = 1'b1;
                card_tx_en = tx_nonempty && card_tx_ready;
            end
            XF_FROMCARD: begin
                active     = 1'b1;
                card_rx_en = !rx_full;
            end
            XF_DONE: begin
                data_done = 1'b1;
                prog_done = to_card_q;
            end
            default: ;
        endcase
    end

    assign rx_req = rx_req_q;

endmodule

// File: rtl/sd_byte_datapath.sv
module sd_byte_datapath
    import sdbp_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int BUS_BYTES = 4,
    parameter int CNT_W     = 28
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xfer_load,
    input  logic [CNT_W-1:0]       xfer_count,
    input  logic                   xfer_to_card,
    input  logic [1:0]             host_size,
    input  logic                   host_wr,
    input  logic [8*BUS_BYTES-1:0] host_wdata,
    input  logic                   host_rd,
    output logic [8*BUS_BYTES-1:0] host_rdata,
    input  logic                   tx_flush,
    input  logic                   card_tx_ready,
    output logic                   card_tx_en,
    output logic [7:0]             card_tx_data,
    output logic                   card_rx_en,
    input  logic [7:0]             card_rx_data,
    output logic                   active,
    output logic                   tx_req,
    output logic                   rx_req,
    output logic                   data_done,
    output logic                   prog_done
);

    localparam int NW = $clog2(BUS_BYTES + 1);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int LW = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;

    logic [NW-1:0]               nbytes;
    logic [CW-1:0]               tx_level;
    logic [CW-1:0]               rx_level;
    logic [CW-1:0]               tx_space;
    logic [NW-1:0]               tx_push_n;
    logic [NW-1:0]               rx_pop_n;
    logic [BUS_BYTES-1:0][7:0]   tx_push_bytes;
    logic [BUS_BYTES-1:0][7:0]   tx_peek;
    logic [BUS_BYTES-1:0][7:0]   rx_push_bytes;
    logic [BUS_BYTES-1:0][7:0]   rx_peek;
    logic [8*BUS_BYTES-1:0]      rd_word;

    assign nbytes   = NW'(size_to_bytes(host_size));
    assign tx_space = CW'(DEPTH) - tx_level;

    // Transmit side: accept as many bytes as fit, most significant lane first.
    always_comb begin
        tx_push_n = '0;
        if (host_wr) begin
            tx_push_n = (CW'(nbytes) > tx_space) ? NW'(tx_space) : nbytes;
        end
        for (int k = 0; k < BUS_BYTES; k++) begin
            tx_push_bytes[k] = 8'h00;
            if (k < int'(nbytes)) begin
                tx_push_bytes[k] = host_wdata[8*(int'(nbytes) - 1 - k) +: 8];
            end
        end
    end

    // Receive side: take as many bytes as are held, oldest into the top lane.
    always_comb begin
        rx_pop_n = '0;
        if (host_rd) begin
            rx_pop_n = (CW'(nbytes) > rx_level) ? NW'(rx_level) : nbytes;
        end
        rd_word = '0;
        for (int l = 0; l < BUS_BYTES; l++) begin
            if (l < int'(nbytes)) begin
                if ((int'(nbytes) - 1 - l) < int'(rx_pop_n)) begin
                    rd_word[8*l +: 8] = rx_peek[LW'(int'(nbytes) - 1 - l)];
                end
            end
        end
    end

    always_comb begin
        rx_push_bytes    = '0;
        rx_push_bytes[0] = card_rx_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_word;
    end

    sdbp_lane_fifo #(.DEPTH(DEPTH), .LANES(BUS_BYTES)) u_tx_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (xfer_load || tx_flush),
        .push_n     (tx_push_n),
        .push_bytes (tx_push_bytes),
        .pop_n      (NW'(card_tx_en)),
        .peek       (tx_peek),
        .level      (tx_level)
    );

    sdbp_lane_fifo #(.DEPTH(DEPTH), .LANES(BUS_BYTES)) u_rx_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (xfer_load),
        .push_n     (NW'(card_rx_en)),
        .push_bytes (rx_push_bytes),
        .pop_n      (rx_pop_n),
        .peek       (rx_peek),
        .level      (rx_level)
    );

    assign card_tx_data = tx_peek[0];

    sdbp_xfer_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (xfer_load),
        .load_count    (xfer_count),
        .load_to_card  (xfer_to_card),
        .tx_nonempty   (tx_level != '0),
        .rx_full       (rx_level == CW'(DEPTH)),
        .card_tx_ready (card_tx_ready),
        .host_rd       (host_rd),
        .active        (active),
        .card_tx_en    (card_tx_en),
        .card_rx_en    (card_rx_en),
        .tx_req        (tx_req),
        .rx_req        (rx_req),
        .data_done     (data_done),
        .prog_done     (prog_done)
    );

endmodule

// File: rtl/sdbp_checker.sv
module sdbp_checker #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic          card_tx_en,
    input logic          card_rx_en,
    input logic          card_tx_ready,
    input logic          tx_req,
    input logic          rx_req,
    input logic          data_done,
    input logic          prog_done,
    input logic [CW-1:0] tx_level,
    input logic [CW-1:0] rx_level
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

    p_tx_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_en |-> (card_tx_ready && (tx_level != '0)));

    p_pull_sets_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_en |=> rx_req);

    p_rx_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_en |-> (rx_level < CW'(DEPTH)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> !data_done);

    p_prog_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |-> data_done);

    p_done_inactive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |-> !active);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!card_tx_en && !card_rx_en && !tx_req));

endmodule

bind sd_byte_datapath sdbp_checker #(.DEPTH(DEPTH)) u_sdbp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (active),
    .card_tx_en    (card_tx_en),
    .card_rx_en    (card_rx_en),
    .card_tx_ready (card_tx_ready),
    .tx_req        (tx_req),
    .rx_req        (rx_req),
    .data_done     (data_done),
    .prog_done     (prog_done),
    .tx_level      (tx_level),
    .rx_level      (rx_level)
);

// File: tb/test_sd_byte_datapath.sv
`timescale 1ns/100ps
module test_sd_byte_datapath;

    localparam int DEPTH = 32;
    localparam int CNT_W = 28;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             xfer_load = 1'b0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic             xfer_to_card = 1'b0;
    logic [1:0]       host_size = 2'd0;
    logic             host_wr = 1'b0;
    logic [31:0]      host_wdata = '0;
    logic             host_rd = 1'b0;
    logic [31:0]      host_rdata;
    logic             tx_flush = 1'b0;
    logic             card_tx_ready = 1'b0;
    logic             card_tx_en;
    logic [7:0]       card_tx_data;
    logic             card_rx_en;
    logic [7:0]       card_rx_data;
    logic             active, tx_req, rx_req, data_done, prog_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int tx_sent = 0;
    int rx_pulled = 0;
    int done_cnt = 0;
    int prog_cnt = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #2.5 clk = ~clk;

    sd_byte_datapath i_sd_byte_datapath (
        .clk(clk), .rst_n(rst_n), .xfer_load(xfer_load), .xfer_count(xfer_count),
        .xfer_to_card(xfer_to_card), .host_size(host_size), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .tx_flush(tx_flush), .card_tx_ready(card_tx_ready), .card_tx_en(card_tx_en),
        .card_tx_data(card_tx_data), .card_rx_en(card_rx_en), .card_rx_data(card_rx_data),
        .active(active), .tx_req(tx_req), .rx_req(rx_req), .data_done(data_done),
        .prog_done(prog_done)
    );

    // Card model: offers a new byte after each pull.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)          card_rx_data <= 8'h5A;
        else if (card_rx_en) card_rx_data <= card_rx_data + 8'h13;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: compares card-bound bytes with the scoreboard, records pulls and done pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (card_tx_en) begin
                tx_sent++;
                if (tx_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected card byte", {24'h0, card_tx_data}, 32'h0);
                end else begin
                    logic [7:0] e;
                    e = tx_q.pop_front();
                    chk(card_tx_data == e, "R2 card byte order", {24'h0, card_tx_data}, {24'h0, e});
                end
            end
            if (card_rx_en) begin
                rx_pulled++;
                rx_q.push_back(card_rx_data);
            end
            if (data_done) done_cnt++;
            if (prog_done) begin
                prog_cnt++;
                chk(data_done, "R7 prog_done without data_done", 32'h0, 32'h1);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            chk(1'b0, "watchdog expired", cycles, 50000);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input int cnt, input bit to_card);
        xfer_load = 1'b1; xfer_count = CNT_W'(cnt); xfer_to_card = to_card;
        tx_q.delete(); rx_q.delete();
        tick();
        xfer_load = 1'b0;
    endtask

    // Driver: pushes the bytes the design must accept into the scoreboard.
    task automatic hwrite(input logic [1:0] sz, input logic [31:0] data);
        int n;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            if (tx_q.size() < DEPTH) tx_q.push_back(data[8*(n-1-k) +: 8]);
        end
        host_wr = 1'b1; host_size = sz; host_wdata = data;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] sz, input string tag);
        int n;
        logic [31:0] e;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        e = '0;
        for (int k = 0; k < n; k++) begin
            if (rx_q.size() > 0) e[8*(n-1-k) +: 8] = rx_q.pop_front();
        end
        host_rd = 1'b1; host_size = sz;
        tick();
        host_rd = 1'b0;
        chk(host_rdata == e, tag, host_rdata, e);
    endtask

    task automatic wait_done(input int limit);
        int d0;
        d0 = done_cnt;
        for (int i = 0; i < limit && done_cnt == d0; i++) tick();
    endtask

    initial begin
        int d0, p0, s0;
        tick(); tick();
        // R1: reset state
        chk(!active && !tx_req && !rx_req && !data_done && !prog_done, "R1 reset flags",
            {active, tx_req, rx_req, data_done, prog_done}, 32'h0);
        chk(!card_tx_en && !card_rx_en && host_rdata == 0, "R1 reset ports", host_rdata, 32'h0);
        rst_n = 1'b1;
        tick();

        // R2/R4/R7: six-byte card-bound transfer with mixed widths
        card_tx_ready = 1'b1;
        d0 = done_cnt; p0 = prog_cnt; s0 = tx_sent;
        load(6, 1'b1);
        chk(active && tx_req, "R4 tx_req while card-bound", {tx_req, active}, 32'h3);
        hwrite(2'd2, 32'h11223344);
        hwrite(2'd1, 32'hFFFF5566);
        hwrite(2'd0, 32'hFFFFFF77);
        wait_done(40);
        chk(done_cnt == d0 + 1, "R7 data_done once", done_cnt - d0, 1);
        chk(prog_cnt == p0 + 1, "R7 prog_done on write", prog_cnt - p0, 1);
        chk(tx_sent - s0 == 6, "R2 six bytes sent", tx_sent - s0, 6);
        tick();
        chk(!active && !tx_req, "R7 inactive after done", {active, tx_req}, 32'h0);
        repeat (5) tick();
        // R8: the surplus byte stays queued while idle
        chk(tx_sent - s0 == 6 && tx_q.size() == 1, "R8 no move while idle", tx_sent - s0, 6);

        // R3: fill a stalled queue past capacity
        card_tx_ready = 1'b0;
        s0 = tx_sent;
        load(40, 1'b1);
        for (int k = 0; k < 9; k++) hwrite(2'd3, 32'h00010203 + 32'h04040404 * k);
        chk(tx_q.size() == 32, "R3 model holds 32", tx_q.size(), 32);
        card_tx_ready = 1'b1;
        repeat (40) tick();
        chk(tx_sent - s0 == 32, "R3 exactly 32 bytes kept", tx_sent - s0, 32);
        chk(active && tx_req, "R4 request while bytes remain", {active, tx_req}, 32'h3);

        // R9: flush discards pending bytes
        card_tx_ready = 1'b0;
        hwrite(2'd2, 32'hDEADBEEF);
        tx_flush = 1'b1; tx_q.delete();
        tick();
        tx_flush = 1'b0;
        hwrite(2'd1, 32'h0000C0DE);
        card_tx_ready = 1'b1;
        repeat (6) tick();
        chk(tx_sent - s0 == 34, "R9 only post-flush bytes sent", tx_sent - s0, 34);
        d0 = done_cnt;
        hwrite(2'd2, 32'h01020304);
        hwrite(2'd1, 32'h00000506);
        wait_done(40);
        chk(done_cnt == d0 + 1 && tx_sent - s0 == 40, "R9 transfer completes", tx_sent - s0, 40);

        // R5/R6/R7: five-byte host-bound transfer
        d0 = done_cnt; p0 = prog_cnt; s0 = rx_pulled;
        load(5, 1'b0);
        wait_done(40);
        chk(done_cnt == d0 + 1 && prog_cnt == p0, "R7 read gives data_done only", prog_cnt - p0, 0);
        chk(rx_pulled - s0 == 5 && rx_req, "R5 five pulls set rx_req", rx_pulled - s0, 5);
        tick();
        hread(2'd2, "R6 four-byte read packing");
        chk(!rx_req, "R5 host read clears rx_req", rx_req, 0);
        hread(2'd1, "R6 two-byte read zero fill");
        hread(2'd0, "R6 empty one-byte read");

        // R5: receive queue stops at 32 and resumes after reads
        s0 = rx_pulled;
        load(40, 1'b0);
        repeat (50) tick();
        chk(rx_pulled - s0 == 32 && active, "R5 pulls stop at 32", rx_pulled - s0, 32);
        hread(2'd0, "R6 one-byte read");
        repeat (4) tick();
        chk(rx_pulled - s0 == 33, "R5 one pull after 1-byte read", rx_pulled - s0, 33);
        hread(2'd2, "R6 four-byte read on full queue");
        repeat (6) tick();
        chk(rx_pulled - s0 == 37, "R5 four pulls after 4-byte read", rx_pulled - s0, 37);

        // R10: zero-count load completes at once and empties the receive queue
        d0 = done_cnt; p0 = prog_cnt;
        load(0, 1'b1);
        chk(data_done && prog_done && !active, "R10 zero count completes", {data_done, prog_done}, 32'h3);
        tick();
        chk(done_cnt == d0 + 1 && prog_cnt == p0 + 1, "R10 single completion", done_cnt - d0, 1);
        chk(!rx_req, "R10 load clears rx_req", rx_req, 0);
        hread(2'd2, "R10 load emptied receive queue");

        // R8: host writes while idle reach nobody
        s0 = tx_sent;
        hwrite(2'd2, 32'hCAFEF00D);
        repeat (5) tick();
        chk(tx_sent == s0 && !tx_req && !active, "R8 idle write held", tx_sent - s0, 0);

        finish_run();
    end

endmodule